// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which of four DMA channels is served next. A channel asks for service either through its hardware request line, whose active level software can choose, or through a software request bit. A per-channel mask and a controller-wide disable bit filter these requests. Among the channels that pass the filter, one is picked by fixed or rotating priority. The winner receives a one-hot acknowledge, and software chooses whether that acknowledge is active high or active low.

A grant stays with the chosen channel until that channel's engine reports the end of its service burst. The grant then drops for one cycle and arbitration runs again. The block also assembles a status byte for software. Its upper nibble shows which channels have a request pending. Its lower nibble holds terminal-count flags, which pulses from the channel engines set and which a status read clears.

Top module: `dma_req_arbiter`

## Requirements
- R1: After a synchronous reset the block is in this state: no grant, all four channels masked, command settings zero (fixed priority, controller enabled, request lines active high, acknowledge active low), no software requests, and terminal-count flags clear. With `drq_in` low this gives `dack` = 4'b1111 and `stat_byte` = 0.
- R2: Under fixed priority (`cmd_wdata[1]` = 0) the eligible channel with the lowest number is granted.
- R3: Under rotating priority (`cmd_wdata[1]` = 1) the search begins one channel above the last channel granted and wraps from 3 to 0, so the channel just served has the lowest priority. Right after reset the search begins at channel 0.
- R4: While the controller is disabled (`cmd_wdata[0]` = 1) no new grant is issued.
- R5: When `cmd_wdata[2]` = 1, a low level on `drq_in[i]` is a request. When it is 0, a high level is a request.
- R6: When `cmd_wdata[3]` = 1, `dack` is active high. When it is 0, `dack` is active low. While a grant is held exactly the line of `grant_id` is active. With no grant, no line is active.
- R7: A software request write uses `req_wdata[1:0]` to pick the channel and `req_wdata[2]` to set (1) or clear (0) that channel's software request. A set request counts as pending whatever the level of `drq_in`. A `tc_pulse` for that channel clears it.
- R8: A single-mask write uses `mask_wdata[1:0]` to pick the channel and `mask_wdata[2]` to mask (1) or unmask (0) it. An all-mask write loads all four masks from `allmask_wdata[3:0]` and takes precedence over a single-mask write in the same cycle. A masked channel is never granted but still shows as pending in the status byte.
- R9: A grant appears one clock after an eligible request is seen while the block is idle. It keeps the same `grant_id` until `burst_done` is sampled high. It drops at that edge, and the next arbitration happens at the following edge.
- R10: `stat_byte[7:4]` shows the pending requests of channels 3..0 and `stat_byte[3:0]` shows their terminal-count flags. A `tc_pulse` bit sets its flag. A clock with `stat_rd` high clears all flags, except that a pulse arriving in that same clock is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| drq_in | input | 4 | Hardware request lines, one per channel |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 4 | {ack active high, request active low, rotating priority, controller disable} |
| req_we | input | 1 | Software request write strobe |
| req_wdata | input | 3 | {set/clear, channel[1:0]} |
| mask_we | input | 1 | Single-mask write strobe |
| mask_wdata | input | 3 | {mask/unmask, channel[1:0]} |
| allmask_we | input | 1 | All-mask write strobe |
| allmask_wdata | input | 4 | New mask for channels 3..0 |
| tc_pulse | input | 4 | Terminal-count pulses from the channel engines |
| burst_done | input | 1 | The granted engine has finished its burst |
| stat_rd | input | 1 | Status read strobe; clears the terminal-count flags |
| stat_byte | output | 8 | {pending[3:0], terminal count[3:0]} |
| grant_valid | output | 1 | A channel currently holds the grant |
| grant_id | output | 2 | Granted channel |
| dack | output | 4 | Acknowledge lines, polarity set by the command |

## Verification
The arbitration is driven with single requests, with several requests at once, and with all four channels requesting without a break. The single requests separate a grant from no grant. Several requests at once separate fixed priority from rotating priority. The continuous requests show whether the rotating pointer advances past each channel it has served. Requests are also sent through masked channels, through a disabled controller, with the request level inverted, and as software requests, so that the filtering path can be told apart from the priority path. Terminal-count pulses are placed before, during and after status reads to show whether the clear-on-read drops a pulse that coincides with the read.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int unsigned NCH = 4;
    localparam int unsigned CW  = $clog2(NCH);
    localparam int unsigned SW  = 2 * NCH;

    typedef logic [CW-1:0]  ch_t;
    typedef logic [NCH-1:0] chvec_t;

    // command word, MSB first
    typedef struct packed {
        logic dack_hi;   // acknowledge lines active high
        logic drq_lo;    // request lines active low
        logic rotate;    // rotating priority
        logic ctl_off;   // whole controller disabled
    } cmd_t;

    typedef enum logic {ARB_IDLE, ARB_BUSY} arb_st_e;

    function automatic chvec_t ch_onehot(input ch_t c);
        chvec_t v;
        v = '0;
        v[c] = 1'b1;
        return v;
    endfunction

    // first set bit of cand, searching upward from start with wraparound
    function automatic ch_t pick_next(input chvec_t cand, input ch_t start);
        ch_t  idx;
        ch_t  win;
        logic found;
        win   = start;
        found = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            idx = ch_t'(start + ch_t'(k));
            if (!found && cand[idx]) begin
                win   = idx;
                found = 1'b1;
            end
        end
        return win;
    endfunction

endpackage

// File: rtl/dma_arb_cfg.sv
module dma_arb_cfg
    import dma_arb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_we,
    input  logic [3:0]    cmd_wdata,
    input  logic          req_we,
    input  logic [CW:0]   req_wdata,
    input  logic          mask_we,
    input  logic [CW:0]   mask_wdata,
    input  logic          allmask_we,
    input  chvec_t        allmask_wdata,
    input  chvec_t        tc_pulse,
    output cmd_t          cmd_q,
    output chvec_t        mask_q,
    output chvec_t        sw_q
);

    chvec_t sw_next;

    always_comb begin
        sw_next = sw_q & ~tc_pulse;
        if (req_we)
            sw_next[req_wdata[CW-1:0]] = req_wdata[CW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            mask_q <= '1;
            sw_q   <= '0;
        end else begin
            if (cmd_we)
                cmd_q <= cmd_t'(cmd_wdata);
            if (allmask_we)
                mask_q <= allmask_wdata;
            else if (mask_we)
                mask_q[mask_wdata[CW-1:0]] <= mask_wdata[CW];
            sw_q <= sw_next;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        AST_SWREQ_TC_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (tc_pulse[i] && !(req_we && req_wdata[CW-1:0] == ch_t'(i))) |=> !sw_q[i]); // R7
        AST_MASK_SINGLE: assert property (@(posedge clk) disable iff (rst)
            (mask_we && !allmask_we && mask_wdata[CW-1:0] == ch_t'(i))
                |=> (mask_q[i] == $past(mask_wdata[CW]))); // R8
    end

endmodule

// File: rtl/dma_arb_status.sv
module dma_arb_status
    import dma_arb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  chvec_t        pend,
    input  chvec_t        tc_pulse,
    input  logic          stat_rd,
    output logic [SW-1:0] stat_byte
);

    chvec_t tc_q;

    always_ff @(posedge clk) begin
        if (rst)
            tc_q <= '0;
        else
            tc_q <= (stat_rd ? chvec_t'('0) : tc_q) | tc_pulse;
    end

    assign stat_byte = {pend, tc_q};

    AST_TC_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && tc_pulse == '0) |=> (stat_byte[NCH-1:0] == '0)); // R10
    AST_TC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (tc_pulse != '0) |=> ((stat_byte[NCH-1:0] & $past(tc_pulse)) == $past(tc_pulse))); // R10
    AST_TC_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!stat_rd) |=> ((stat_byte[NCH-1:0] & $past(tc_q)) == $past(tc_q))); // R10

endmodule

// File: rtl/dma_arb_core.sv
module dma_arb_core
    import dma_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rotate,
    input  logic   ctl_off,
    input  chvec_t elig,
    input  logic   burst_done,
    output logic   grant_valid,
    output ch_t    grant_id
);

    arb_st_e st_q;
    ch_t     gid_q;
    ch_t     last_q;
    ch_t     start;
    ch_t     winner;

    assign start  = rotate ? ch_t'(last_q + 1'b1) : ch_t'(0);
    assign winner = pick_next(elig, start);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ARB_IDLE;
            gid_q  <= '0;
            last_q <= ch_t'(NCH - 1);
        end else begin
            case (st_q)
                ARB_IDLE: begin
                    if (!ctl_off && elig != '0) begin
                        st_q   <= ARB_BUSY;
                        gid_q  <= winner;
                        last_q <= winner;
                    end
                end
                ARB_BUSY: begin
                    if (burst_done)
                        st_q <= ARB_IDLE;
                end
                default: st_q <= ARB_IDLE;
            endcase
        end
    end

    assign grant_valid = (st_q == ARB_BUSY);
    assign grant_id    = gid_q;

    AST_GRANT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !burst_done) |=> (grant_valid && $stable(grant_id))); // R9
    AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && burst_done) |=> !grant_valid); // R9
    AST_OFF_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        (!grant_valid && ctl_off) |=> !grant_valid); // R4
    AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (rst)
        (!grant_valid && !ctl_off && !rotate && elig != '0)
            |=> (grant_valid && (($past(elig) & (ch_onehot(grant_id) - 1'b1)) == '0))); // R2

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
    import dma_arb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  drq_in,
    input  logic        cmd_we,
    input  logic [3:0]  cmd_wdata,
    input  logic        req_we,
    input  logic [2:0]  req_wdata,
    input  logic        mask_we,
    input  logic [2:0]  mask_wdata,
    input  logic        allmask_we,
    input  logic [3:0]  allmask_wdata,
    input  logic [3:0]  tc_pulse,
    input  logic        burst_done,
    input  logic        stat_rd,
    output logic [7:0]  stat_byte,
    output logic        grant_valid,
    output logic [1:0]  grant_id,
    output logic [3:0]  dack
);

    cmd_t   cmd_q;
    chvec_t mask_q;
    chvec_t sw_q;
    chvec_t drq_eff;
    chvec_t pend;
    chvec_t elig;
    chvec_t dack_act;

    dma_arb_cfg i_cfg (
        .clk           (clk),
        .rst           (rst),
        .cmd_we        (cmd_we),
        .cmd_wdata     (cmd_wdata),
        .req_we        (req_we),
        .req_wdata     (req_wdata),
        .mask_we       (mask_we),
        .mask_wdata    (mask_wdata),
        .allmask_we    (allmask_we),
        .allmask_wdata (allmask_wdata),
        .tc_pulse      (tc_pulse),
        .cmd_q         (cmd_q),
        .mask_q        (mask_q),
        .sw_q          (sw_q)
    );

    assign drq_eff = drq_in ^ {NCH{cmd_q.drq_lo}};
    assign pend    = drq_eff | sw_q;
    assign elig    = pend & ~mask_q;

    dma_arb_core i_core (
        .clk         (clk),
        .rst         (rst),
        .rotate      (cmd_q.rotate),
        .ctl_off     (cmd_q.ctl_off),
        .elig        (elig),
        .burst_done  (burst_done),
        .grant_valid (grant_valid),
        .grant_id    (grant_id)
    );

    dma_arb_status i_status (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend),
        .tc_pulse  (tc_pulse),
        .stat_rd   (stat_rd),
        .stat_byte (stat_byte)
    );

    assign dack_act = grant_valid ? ch_onehot(grant_id) : chvec_t'('0);
    assign dack     = cmd_q.dack_hi ? dack_act : ~dack_act;

    AST_MASKED_NEVER_GRANTED: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_valid) |-> ((~$past(mask_q) & ch_onehot(grant_id)) != '0)); // R8
    AST_GRANT_WAS_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_valid) |-> (($past(pend) & ch_onehot(grant_id)) != '0)); // R9
    AST_ENABLED_AT_GRANT: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_valid) |-> !$past(cmd_q.ctl_off)); // R4
    AST_SW_SHOWS_PENDING: assert property (@(posedge clk) disable iff (rst)
        (sw_q != '0) |-> ((stat_byte[SW-1:NCH] & sw_q) == sw_q)); // R7

endmodule

// File: tb/test_dma_req_arbiter.sv
module test_dma_req_arbiter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] drq_in = '0;
    logic       cmd_we = 1'b0;
    logic [3:0] cmd_wdata = '0;
    logic       req_we = 1'b0;
    logic [2:0] req_wdata = '0;
    logic       mask_we = 1'b0;
    logic [2:0] mask_wdata = '0;
    logic       allmask_we = 1'b0;
    logic [3:0] allmask_wdata = '0;
    logic [3:0] tc_pulse = '0;
    logic       burst_done = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_byte;
    logic       grant_valid;
    logic [1:0] grant_id;
    logic [3:0] dack;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [3:0] m_cmd, m_mask, m_sw, m_tc;
    logic       m_gv;
    int         m_gid, m_last;

    always #10 clk = ~clk;   // 50 MHz

    dma_req_arbiter i_dma_req_arbiter (
        .clk(clk), .rst(rst), .drq_in(drq_in),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .req_we(req_we), .req_wdata(req_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .allmask_we(allmask_we), .allmask_wdata(allmask_wdata),
        .tc_pulse(tc_pulse), .burst_done(burst_done), .stat_rd(stat_rd),
        .stat_byte(stat_byte), .grant_valid(grant_valid),
        .grant_id(grant_id), .dack(dack)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] m_pend();
        return (drq_in ^ {4{m_cmd[2]}}) | m_sw;
    endfunction

    task automatic compare();
        logic [3:0] d;
        d = m_gv ? 4'(1 << m_gid) : 4'b0000;
        if (!m_cmd[3]) d = ~d;
        chk("R9 grant_valid", int'(grant_valid), int'(m_gv));
        if (m_gv) chk("R2/R3 grant_id", int'(grant_id), m_gid);
        chk("R6 dack", int'(dack), int'(d));
        chk("R10 stat_byte", int'(stat_byte), int'({m_pend(), m_tc}));
    endtask

    task automatic model_step();
        logic [3:0] elig;
        int         st, c;
        logic       found;
        if (rst) begin
            m_cmd = '0; m_mask = '1; m_sw = '0; m_tc = '0;
            m_gv = 1'b0; m_gid = 0; m_last = 3;
        end else begin
            elig = m_pend() & ~m_mask;
            if (m_gv) begin
                if (burst_done) m_gv = 1'b0;
            end else if (!m_cmd[0] && elig != 0) begin
                st = m_cmd[1] ? (m_last + 1) % 4 : 0;
                found = 1'b0;
                for (int k = 0; k < 4; k++) begin
                    c = (st + k) % 4;
                    if (!found && elig[c]) begin
                        m_gid = c;
                        found = 1'b1;
                    end
                end
                m_gv = 1'b1;
                m_last = m_gid;
            end
            m_sw = m_sw & ~tc_pulse;
            if (req_we) m_sw[req_wdata[1:0]] = req_wdata[2];
            if (cmd_we) m_cmd = cmd_wdata;
            if (allmask_we) m_mask = allmask_wdata;
            else if (mask_we) m_mask[mask_wdata[1:0]] = mask_wdata[2];
            m_tc = (stat_rd ? 4'b0000 : m_tc) | tc_pulse;
        end
    endtask

    // inputs are set just after a falling edge; compare, clock, clear strobes
    task automatic tick();
        #1;
        if (!rst) compare();
        @(posedge clk);
        model_step();
        @(negedge clk);
        cmd_we = 0; req_we = 0; mask_we = 0; allmask_we = 0;
        tc_pulse = '0; burst_done = 0; stat_rd = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst = 1;
        tick(); tick();
        rst = 0;
        #1;
        chk("R1 reset grant", int'(grant_valid), 0);
        chk("R1 reset dack", int'(dack), 4'hF);
        chk("R1 reset stat", int'(stat_byte), 0);

        // R8: masked after reset, pending still visible
        drq_in = 4'b0001;
        tick(); tick();
        chk("R8 masked no grant", int'(grant_valid), 0);
        chk("R8 masked pending shown", int'(stat_byte[4]), 1);
        allmask_we = 1; allmask_wdata = 4'b0000;
        tick(); tick();
        chk("R9 grant after unmask", int'(grant_valid), 1);
        chk("R6 dack low active ch0", int'(dack), 4'b1110);

        // R2 fixed priority
        drq_in = 4'b1010;
        burst_done = 1; tick();
        chk("R9 grant drops", int'(grant_valid), 0);
        tick();
        chk("R2 lowest wins", int'(grant_id), 1);
        tick(); tick(); tick();
        chk("R9 grant held", int'(grant_id), 1);
        chk("R9 grant held valid", int'(grant_valid), 1);

        // R3 rotating priority
        cmd_we = 1; cmd_wdata = 4'b0010; drq_in = 4'b1111;
        tick();
        burst_done = 1; tick(); tick();
        chk("R3 next after ch1", int'(grant_id), 2);
        burst_done = 1; tick(); tick();
        chk("R3 next after ch2", int'(grant_id), 3);
        burst_done = 1; tick(); tick();
        chk("R3 wrap to ch0", int'(grant_id), 0);

        // R4 controller disabled
        burst_done = 1; cmd_we = 1; cmd_wdata = 4'b0011;
        tick(); tick(); tick(); tick();
        chk("R4 disabled no grant", int'(grant_valid), 0);

        // R5 request active low
        cmd_we = 1; cmd_wdata = 4'b0100; drq_in = 4'b1011;
        tick();
        chk("R5 inverted pending", int'(stat_byte[7:4]), 4'b0100);
        tick();
        chk("R5 inverted grant", int'(grant_id), 2);

        // R6 acknowledge active high
        cmd_we = 1; cmd_wdata = 4'b1100;
        tick();
        chk("R6 dack high active ch2", int'(dack), 4'b0100);

        // R7 software request
        drq_in = 4'b1111; burst_done = 1;
        tick(); tick();
        chk("R7 idle before sw", int'(grant_valid), 0);
        req_we = 1; req_wdata = 3'b111;
        tick();
        chk("R7 sw pending", int'(stat_byte[7:4]), 4'b1000);
        tick();
        chk("R7 sw grant", int'(grant_id), 3);
        tc_pulse = 4'b1000;
        tick();
        chk("R7 tc clears sw", int'(stat_byte), 8'b0000_1000);

        // R10 clear on read
        tc_pulse = 4'b0001;
        tick();
        chk("R10 tc accumulate", int'(stat_byte), 8'b0000_1001);
        stat_rd = 1; tc_pulse = 4'b0010;
        tick();
        chk("R10 read keeps new pulse", int'(stat_byte), 8'b0000_0010);
        stat_rd = 1;
        tick();
        chk("R10 read clears", int'(stat_byte), 0);

        // R8 single mask + R7 software clear
        burst_done = 1; mask_we = 1; mask_wdata = 3'b101;
        tick();
        req_we = 1; req_wdata = 3'b101;
        tick(); tick();
        chk("R8 single mask blocks", int'(grant_valid), 0);
        chk("R7 sw set on masked", int'(stat_byte[5]), 1);
        req_we = 1; req_wdata = 3'b001;
        tick();
        chk("R7 sw clear", int'(stat_byte[5]), 0);
        mask_we = 1; mask_wdata = 3'b001; req_we = 1; req_wdata = 3'b101;
        tick(); tick();
        chk("R8 unmask grants", int'(grant_id), 1);
        tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule